// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block runs programmed-I/O register and data accesses on one IDE channel that carries a master and a slave drive. A host-side request names the drive, the direction, the transfer width, the register address and the chip-select block. The block then drives the address and chip select, pulses the read or write strobe, and returns read data. All timing is counted in host clock cycles, and the intended host clock is 25 to 33 MHz.

Each access has three phases. The setup phase holds the address and chip select valid with the strobe inactive. The active phase asserts the strobe. The recovery phase releases the strobe. A stored count N gives N+1 clocks of its phase, and every field is 4 bits wide, so the largest count is 15. Software converts nanoseconds to clocks, rounds up, subtracts one and clamps the result to 0..15. With those values the block covers PIO modes 0 through 4.

Each drive has its own setup count and three timing bytes: 16-bit read, 16-bit write, and 8-bit access. Each timing byte holds the active count in bits 7:4 and the recovery count in bits 3:0. The 8-bit byte serves 8-bit command and control accesses in both directions. Software may load it with the same value as the 16-bit bytes when a fast mode is in use.

Top module: `pio_strobe_gen`

## Requirements
- R1: After reset, every setup count and every timing-byte nibble is 15. While idle, busy and done are 0, both strobes and both chip selects are high (inactive), ide_addr is 0 and ide_doe is 0.
- R2: The setup phase lasts S+1 clocks, where S is the setup count of the selected drive. From the first setup clock to the end of recovery, ide_addr equals the request address. The chip select is active low: ide_cs0_n when req_ctl=0, ide_cs1_n when req_ctl=1. Both strobes stay high during setup.
- R3: The active phase lasts A+1 clocks, where A is bits 7:4 of the selected timing byte. During this phase ide_rd_n is low for a read (req_wr=0) or ide_wr_n is low for a write (req_wr=1). The two strobes are never low together.
- R4: The recovery phase lasts R+1 clocks, where R is bits 3:0 of the selected timing byte. done is high for exactly one cycle, the last recovery clock. busy is 0 in the cycle after done.
- R5: The request width bit selects the timing byte. With req_wide=1 the block uses the 16-bit read byte for a read and the 16-bit write byte for a write. With req_wide=0 it uses the 8-bit byte for either direction.
- R6: Configuration writes take cfg_drv (0 master, 1 slave) and cfg_kind, encoded as 0 setup count (cfg_wdata[3:0]), 1 16-bit read byte, 2 16-bit write byte, 3 8-bit byte. The setup counts sit in one register: master in bits 3:0, slave in bits 7:4. Writing one drive's setup count leaves the other drive's count unchanged. req_drv selects which drive's set the access uses.
- R7: On a read, rd_data takes ide_din as it stands in the last active clock. A 16-bit read keeps all 16 bits. An 8-bit read keeps bits 7:0 and zeroes the upper byte.
- R8: On a write, ide_doe is 1 from the first setup clock through the last active clock and 0 in recovery. While ide_doe is 1, ide_dout holds req_wdata, or only its low byte with the upper byte zeroed for an 8-bit write.
- R9: A request presented while busy is 1 is ignored. The running access keeps its address, chip select, direction and length, and no new access starts after it.
- R10: A count of 0 still gives one clock of its phase, so the shortest access is 3 clocks from acceptance to done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_drv | input | 1 | Drive targeted by the write (0 master, 1 slave) |
| cfg_kind | input | 2 | Field selector: 0 setup, 1 read16, 2 write16, 3 access8 |
| cfg_wdata | input | 8 | Configuration data |
| req | input | 1 | Access request, sampled while idle |
| req_drv | input | 1 | Drive select for the access |
| req_wr | input | 1 | 1 write, 0 read |
| req_wide | input | 1 | 1 16-bit data, 0 8-bit command/control |
| req_ctl | input | 1 | 1 control block (cs1), 0 command block (cs0) |
| req_addr | input | 3 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse on the last recovery clock |
| rd_data | output | 16 | Captured read data |
| ide_addr | output | 3 | Drive register address |
| ide_cs0_n | output | 1 | Command block select, active low |
| ide_cs1_n | output | 1 | Control block select, active low |
| ide_rd_n | output | 1 | Read strobe, active low |
| ide_wr_n | output | 1 | Write strobe, active low |
| ide_dout | output | 16 | Data toward the drive |
| ide_doe | output | 1 | Data output enable |
| ide_din | input | 16 | Data from the drive |

## Verification
The bench presents a request at a falling edge, and the block accepts it at the next rising edge. From then on the bench numbers every falling edge as a sample. With counts S, A and R, the setup phase covers samples 1 to S+1 and the active phase covers samples S+2 to S+A+2. done appears at sample S+A+R+3, and busy must be low at the sample after it. Read data is latched at the rising edge that closes sample S+A+2. For that reason the bench changes ide_din at every sample and expects the value it drove at that one sample. All expected lengths come from the counts the bench itself programmed.

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen #(
  parameter int CW = 4,
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_drv,
  input  logic [1:0]    cfg_kind,
  input  logic [2*CW-1:0] cfg_wdata,
  input  logic          req,
  input  logic          req_drv,
  input  logic          req_wr,
  input  logic          req_wide,
  input  logic          req_ctl,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] ide_addr,
  output logic          ide_cs0_n,
  output logic          ide_cs1_n,
  output logic          ide_rd_n,
  output logic          ide_wr_n,
  output logic [DW-1:0] ide_dout,
  output logic          ide_doe,
  input  logic [DW-1:0] ide_din
);
  localparam int TW = 2 * CW;

  typedef enum logic [1:0] {IDLE, SETUP, ACT, REC} phase_t;

  phase_t        ph;
  logic [CW-1:0] cnt;
  logic [2*CW-1:0] setup_q;
  logic [TW-1:0] rd16_q [2];
  logic [TW-1:0] wr16_q [2];
  logic [TW-1:0] acc8_q [2];
  logic          drv_q, wr_q, wide_q, ctl_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [TW-1:0] tsel;
  logic [CW-1:0] setup_sel;

  assign tsel      = !wide_q ? acc8_q[drv_q] : (wr_q ? wr16_q[drv_q] : rd16_q[drv_q]);
  assign setup_sel = req_drv ? setup_q[2*CW-1:CW] : setup_q[CW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      setup_q <= '1;
      for (int d = 0; d < 2; d++) begin
        rd16_q[d] <= '1;
        wr16_q[d] <= '1;
        acc8_q[d] <= '1;
      end
    end else if (cfg_we) begin
      case (cfg_kind)
        2'd0: if (cfg_drv) setup_q[2*CW-1:CW] <= cfg_wdata[CW-1:0];
              else         setup_q[CW-1:0]    <= cfg_wdata[CW-1:0];
        2'd1: rd16_q[cfg_drv] <= cfg_wdata;
        2'd2: wr16_q[cfg_drv] <= cfg_wdata;
        default: acc8_q[cfg_drv] <= cfg_wdata;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= IDLE;
      cnt     <= '0;
      drv_q   <= 1'b0;
      wr_q    <= 1'b0;
      wide_q  <= 1'b0;
      ctl_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rd_data <= '0;
    end else begin
      case (ph)
        IDLE: if (req) begin
          ph      <= SETUP;
          cnt     <= setup_sel;
          drv_q   <= req_drv;
          wr_q    <= req_wr;
          wide_q  <= req_wide;
          ctl_q   <= req_ctl;
          addr_q  <= req_addr;
          wdata_q <= req_wide ? req_wdata : {{(DW-8){1'b0}}, req_wdata[7:0]};
        end
        SETUP: if (cnt == '0) begin
          ph  <= ACT;
          cnt <= tsel[TW-1:CW];
        end else cnt <= cnt - 1'b1;
        ACT: if (cnt == '0) begin
          ph  <= REC;
          cnt <= tsel[CW-1:0];
          if (!wr_q)
            rd_data <= wide_q ? ide_din : {{(DW-8){1'b0}}, ide_din[7:0]};
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) ph <= IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign busy      = (ph != IDLE);
  assign done      = (ph == REC) && (cnt == '0);
  assign ide_addr  = busy ? addr_q : '0;
  assign ide_cs0_n = !(busy && !ctl_q);
  assign ide_cs1_n = !(busy && ctl_q);
  assign ide_rd_n  = !((ph == ACT) && !wr_q);
  assign ide_wr_n  = !((ph == ACT) && wr_q);
  assign ide_doe   = wr_q && ((ph == SETUP) || (ph == ACT));
  assign ide_dout  = wdata_q;

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ide_rd_n && !ide_wr_n));
  assert_strobe_has_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ide_rd_n || !ide_wr_n) |-> (ide_cs0_n != ide_cs1_n));
  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_then_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  assert_hold_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(ide_addr) && $stable(ide_cs0_n) && $stable(ide_cs1_n)));
  assert_oe_only_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ide_doe |-> (busy && ide_rd_n));
endmodule

// File: tb/pio_strobe_gen_test.sv
module pio_strobe_gen_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_drv = 0;
  logic [1:0] cfg_kind = 0;
  logic [7:0] cfg_wdata = 0;
  logic req = 0, req_drv = 0, req_wr = 0, req_wide = 0, req_ctl = 0;
  logic [2:0] req_addr = 0;
  logic [15:0] req_wdata = 0, ide_din = 0;
  logic busy, done, ide_cs0_n, ide_cs1_n, ide_rd_n, ide_wr_n, ide_doe;
  logic [15:0] rd_data, ide_dout;
  logic [2:0] ide_addr;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  pio_strobe_gen uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input bit d, input logic [1:0] k, input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_drv = d; cfg_kind = k; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic run(input bit d, input bit w, input bit wide, input bit ctl,
                     input logic [2:0] a, input logic [15:0] wd,
                     input int es, input int ea, input int er, input bit poke,
                     input string tag);
    int first_act = 0, n_act = 0, total = 0, bad_cs = 0, bad_kind = 0, bad_oe = 0;
    int bad_busy = 0, cap_i = 0;
    logic [15:0] exp_rd, exp_wd;
    @(negedge clk);
    req = 1; req_drv = d; req_wr = w; req_wide = wide; req_ctl = ctl;
    req_addr = a; req_wdata = wd;
    @(negedge clk);
    req = 0;
    exp_wd = wide ? wd : {8'h00, wd[7:0]};
    for (int i = 1; i <= 200; i++) begin
      bit strobe;
      if (!busy) bad_busy++;
      if (ide_addr !== a || ide_cs0_n !== ctl || ide_cs1_n !== !ctl) bad_cs++;
      strobe = !ide_rd_n || !ide_wr_n;
      if (strobe) begin
        n_act++;
        if (first_act == 0) first_act = i;
        if ((w && ide_wr_n) || (!w && ide_rd_n)) bad_kind++;
        cap_i = i;
      end
      if (ide_doe !== (w && (first_act == 0 || strobe))) bad_oe++;
      if (ide_doe && ide_dout !== exp_wd) bad_oe++;
      ide_din = 16'hA000 + 16'(i);
      if (poke && i == 2) begin
        req = 1; req_drv = !d; req_wr = !w; req_ctl = !ctl; req_addr = a + 3'd1;
      end
      if (poke && i == 3) req = 0;
      if (done) begin total = i; break; end
      @(negedge clk);
    end
    chk(first_act - 1 == es + 1, {tag, " R2 setup clocks"}, first_act - 1, es + 1);
    chk(bad_cs == 0, {tag, " R2 addr/cs valid"}, bad_cs, 0);
    chk(n_act == ea + 1 && bad_kind == 0, {tag, " R3 active clocks"}, n_act, ea + 1);
    chk(total == es + ea + er + 3 && bad_busy == 0, {tag, " R4 done cycle"}, total, es + ea + er + 3);
    if (w) chk(bad_oe == 0, {tag, " R8 write data drive"}, bad_oe, 0);
    else begin
      exp_rd = 16'hA000 + 16'(cap_i);
      if (!wide) exp_rd = {8'h00, exp_rd[7:0]};
      chk(rd_data === exp_rd, {tag, " R7 read capture"}, rd_data, exp_rd);
    end
    @(negedge clk);
    chk(!busy && !done, {tag, " R4 idle after done"}, {busy, done}, 0);
    if (poke) begin
      @(negedge clk);
      chk(!busy && ide_wr_n && ide_rd_n, {tag, " R9 no access after ignored req"}, busy, 0);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!busy && !done && ide_rd_n && ide_wr_n && ide_cs0_n && ide_cs1_n && !ide_doe && ide_addr == 0,
        "R1 idle outputs", {busy, done, ide_doe}, 0);
    run(0, 0, 1, 0, 3'd1, 0, 15, 15, 15, 0, "R1 reset timing");
  endtask

  task automatic t_program;
    cfg(0, 0, 8'h02); cfg(0, 1, 8'h31); cfg(0, 2, 8'h52); cfg(0, 3, 8'h00);
    cfg(1, 0, 8'h00);
    run(0, 0, 1, 0, 3'd0, 0, 2, 3, 1, 0, "R6 master rd16 after slave setup write");
  endtask

  task automatic t_write16;
    run(0, 1, 1, 0, 3'd5, 16'hBEEF, 2, 5, 2, 0, "R5 wr16");
  endtask

  task automatic t_acc8;
    run(0, 0, 0, 1, 3'd6, 0, 2, 0, 0, 0, "R10 R5 acc8 read");
    run(0, 1, 0, 1, 3'd6, 16'h1234, 2, 0, 0, 0, "R10 acc8 write");
  endtask

  task automatic t_slave;
    run(1, 0, 1, 0, 3'd7, 0, 0, 15, 15, 0, "R6 slave uses own set");
    cfg(1, 0, 8'h03);
    run(0, 0, 0, 0, 3'd2, 0, 2, 0, 0, 0, "R6 master setup kept");
  endtask

  task automatic t_busy;
    run(0, 0, 1, 0, 3'd4, 0, 2, 3, 1, 1, "R9 busy ignore");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_program();
    t_write16();
    t_acc8();
    t_slave();
    t_busy();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end
endmodule